// File: doc/BRIEF.md
# Output Load Detection Sequencer

This controller runs a single load-presence probe on one of four current outputs of a quad converter. A request carries a channel number. The controller drives a two-bit selector that routes the chosen output to a shared comparator. It waits a setup interval and then pulls an active-low evaluate strobe low. The strobe stays low long enough to satisfy both the minimum pulse width and the comparator settling time. The controller then takes the comparator level, releases the strobe and reports whether a load is present.

Every interval is a parameter given in nanoseconds. Each one is turned into a cycle count from the clock period parameter, rounding up. The default clock period is for 75 MHz. Driving the converter to a suitable test code and the analog comparator itself are outside this block.

Top module: `load_probe_seq`

## Requirements
- R1: While reset is held, sel_o is 00, strobe_no is 1, busy_o is 0, done_o is 0 and load_o is 0.
- R2: An accepted request drives sel_o in the cycle after acceptance with the code for the requested channel. Channel 0 gives 00, channel 1 gives 10, channel 2 gives 01 and channel 3 gives 11. The code is held until the next accepted request.
- R3: strobe_no falls exactly SETUP_CYC cycles after sel_o is driven. SETUP_CYC is ceil(SEL_SETUP_NS*1000/CLK_PERIOD_PS), which is 20 at a 5000 ps period.
- R4: strobe_no stays low for exactly EVAL_CYC cycles. EVAL_CYC is the larger of the strobe-width count and the settle count, each rounded up the same way. At a 5000 ps period this is 40. The strobe is low only while busy_o is high.
- R5: At the clock edge where strobe_no returns high, load_o takes the inverse of cmp_i. A comparator level of 0 therefore means no load. load_o keeps that value until the next done_o.
- R6: done_o is a single-cycle pulse in the cycle where strobe_no is first high again. Every accepted request produces exactly one done_o.
- R7: A start_i that arrives while busy_o is high is ignored. sel_o, the strobe timing and the reported result are unchanged, and no extra done_o appears.
- R8: busy_o is high from the cycle after acceptance until the strobe returns, and it is low in the done_o cycle. A start_i sampled in the done_o cycle is accepted.
- R9: Changes on cmp_i before the sampling edge have no effect on load_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Probe request, taken when idle |
| chan_i | input | 2 | Channel number to probe |
| cmp_i | input | 1 | Comparator level, 0 means no load |
| sel_o | output | 2 | Comparator input select code |
| strobe_no | output | 1 | Evaluate strobe, active low, idles high |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle completion pulse |
| load_o | output | 1 | Load present, valid from done_o on |

## Verification
The probe is run on all four channels, with both comparator levels spread across them. This separates a straight select encoding from the bit-swapped one, and it catches an inverted or stuck result. Some runs keep the comparator level steady, while others toggle it during evaluation and settle it just before the sampling edge. Together these show whether the level is taken at the strobe-release edge and nowhere else. Back-to-back requests in the done cycle test the idle handoff. Requests issued mid-probe with a different channel test that a busy controller ignores them, while the setup gap and low width are measured on every run.

// File: rtl/load_probe_pkg.sv
`timescale 1ns/1ps
package load_probe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_EVAL  = 2'd2
  } probe_state_e;

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/load_probe_sel_map.sv
`timescale 1ns/1ps
module load_probe_sel_map (
  input  logic [1:0] chan_i,
  output logic [1:0] code_o
);
  // channels 1 and 2 trade codes; 0 and 3 map straight
  always_comb begin
    unique case (chan_i)
      2'd0:    code_o = 2'b00;
      2'd1:    code_o = 2'b10;
      2'd2:    code_o = 2'b01;
      default: code_o = 2'b11;
    endcase
  end
endmodule

// File: rtl/load_probe_timer.sv
`timescale 1ns/1ps
module load_probe_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/load_probe_seq.sv
`timescale 1ns/1ps
module load_probe_seq
  import load_probe_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 13334,
  parameter int unsigned SEL_SETUP_NS  = 100,
  parameter int unsigned STROBE_LOW_NS = 200,
  parameter int unsigned SETTLE_NS     = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] chan_i,
  input  logic       cmp_i,
  output logic [1:0] sel_o,
  output logic       strobe_no,
  output logic       busy_o,
  output logic       done_o,
  output logic       load_o
);
  localparam int unsigned SETUP_CYC  = ns_to_cycles(SEL_SETUP_NS, CLK_PERIOD_PS);
  localparam int unsigned LOW_CYC    = ns_to_cycles(STROBE_LOW_NS, CLK_PERIOD_PS);
  localparam int unsigned SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_PERIOD_PS);
  localparam int unsigned EVAL_CYC   = max_u(LOW_CYC, SETTLE_CYC);
  localparam int unsigned CNT_MAX    = max_u(SETUP_CYC, EVAL_CYC);
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);

  probe_state_e state_q, state_d;
  logic [1:0]   sel_q, code_w;
  logic         strobe_q, done_q, load_q;
  logic         tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  load_probe_sel_map u_map (
    .chan_i (chan_i),
    .code_o (code_w)
  );

  load_probe_timer #(.W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_zero) begin
        state_d  = ST_EVAL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(EVAL_CYC - 1);
      end
      ST_EVAL: if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sel_q    <= 2'b00;
      strobe_q <= 1'b1;
      done_q   <= 1'b0;
      load_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (state_q == ST_IDLE && start_i) sel_q <= code_w;
      if (state_q == ST_SETUP && tmr_zero) strobe_q <= 1'b0;
      if (state_q == ST_EVAL && tmr_zero) begin
        strobe_q <= 1'b1;
        load_q   <= ~cmp_i;
        done_q   <= 1'b1;
      end
    end
  end

  assign sel_o     = sel_q;
  assign strobe_no = strobe_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign load_o    = load_q;
endmodule

// File: rtl/load_probe_chk.sv
`timescale 1ns/1ps
module load_probe_chk #(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned EVAL_CYC  = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] sel_o,
  input logic       strobe_no,
  input logic       busy_o,
  input logic       done_o,
  input logic       load_o
);
  int unsigned since_q, low_q;
  logic        busy_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_d  <= 1'b0;
      since_q <= 0;
      low_q   <= 0;
    end else begin
      busy_d <= busy_o;
      if (busy_o && !busy_d)        since_q <= 1;
      else if (since_q != 32'hFFFF_FFFF) since_q <= since_q + 1;
      if (!strobe_no && low_q != 32'hFFFF_FFFF) low_q <= low_q + 1;
      else if (strobe_no)           low_q <= 0;
    end
  end

  p_setup_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_no) |-> since_q >= SETUP_CYC);
  p_low_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_no) |-> low_q >= EVAL_CYC);
  p_strobe_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |-> busy_o);
  p_load_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(load_o));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_no) |-> done_o);
  p_sel_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> $stable(sel_o));
  p_idle_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind load_probe_seq load_probe_chk #(
  .SETUP_CYC (SETUP_CYC),
  .EVAL_CYC  (EVAL_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .sel_o     (sel_o),
  .strobe_no (strobe_no),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .load_o    (load_o)
);

// File: tb/load_probe_seq_bench.sv
`timescale 1ns/1ps
module load_probe_seq_bench;
  localparam int SETUP_EXP = 20;  // 100 ns at 5 ns
  localparam int EVAL_EXP  = 40;  // max(200 ns, 100 ns) at 5 ns

  logic clk = 1'b0;
  logic rst_ni, start_i, cmp_i;
  logic [1:0] chan_i, sel_o;
  logic strobe_no, busy_o, done_o, load_o;

  always #2.5 clk = ~clk;

  load_probe_seq #(.CLK_PERIOD_PS(5000)) u_load_probe_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .chan_i(chan_i),
    .cmp_i(cmp_i), .sel_o(sel_o), .strobe_no(strobe_no),
    .busy_o(busy_o), .done_o(done_o), .load_o(load_o)
  );

  typedef struct { logic [1:0] sel; logic load; } exp_t;
  exp_t q[$];
  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(input logic [1:0] c);
    case (c)
      2'd0: return 2'b00;
      2'd1: return 2'b10;
      2'd2: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  // driver: entered at a negedge with the block idle
  task automatic run(input logic [1:0] ch, input logic fin, input bit glitch, input bit rogue);
    exp_t e;
    e.sel = code_of(ch);
    e.load = ~fin;
    q.push_back(e);
    start_i = 1'b1; chan_i = ch; cmp_i = glitch ? ~fin : fin;
    @(negedge clk);
    start_i = 1'b0;
    chk(sel_o == e.sel, "R2 select code", sel_o, e.sel);
    chk(busy_o == 1'b1, "R8 busy after accept", busy_o, 1);
    if (rogue) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1; chan_i = ch + 2'd1;
      @(negedge clk);
      start_i = 1'b0;
      chk(sel_o == e.sel, "R7 busy request ignored", sel_o, e.sel);
    end
    if (glitch) begin
      while (strobe_no) @(negedge clk);
      for (int i = 0; i < EVAL_EXP - 3; i++) begin
        @(negedge clk);
        cmp_i = ~cmp_i;
      end
      cmp_i = fin;
    end
    while (!done_o) @(negedge clk);
  endtask

  // monitor
  bit busy_p = 0, strobe_p = 1, done_p = 0, load_p = 0;
  int since = 0, lowc = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      exp_t e;
      if (busy_o && !busy_p) since = 0; else since++;
      if (!strobe_no && strobe_p) chk(since == SETUP_EXP, "R3 setup gap", since, SETUP_EXP);
      if (strobe_no) begin
        if (!strobe_p) begin
          chk(lowc == EVAL_EXP, "R4 strobe low width", lowc, EVAL_EXP);
          chk(done_o == 1'b1, "R6 done with strobe release", done_o, 1);
        end
        lowc = 0;
      end else begin
        lowc++;
        if (!busy_o) chk(0, "R4 strobe low while idle", busy_o, 1);
      end
      if (done_o && done_p) chk(0, "R6 done longer than one cycle", 2, 1);
      if (!done_o && load_o != load_p) chk(0, "R5 R9 load changed without done", load_o, load_p);
      if (done_o) begin
        if (q.size() == 0) chk(0, "R7 unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(sel_o == e.sel, "R2 select at done", sel_o, e.sel);
          chk(load_o == e.load, "R5 load result", load_o, e.load);
          chk(busy_o == 1'b0, "R8 idle in done cycle", busy_o, 0);
        end
      end
      busy_p = busy_o; strobe_p = strobe_no; done_p = done_o; load_p = load_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; chan_i = 2'd0; cmp_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(sel_o == 2'b00, "R1 reset sel", sel_o, 0);
    chk(strobe_no == 1'b1, "R1 reset strobe", strobe_no, 1);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    chk(load_o == 1'b0, "R1 reset load", load_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    run(2'd0, 1'b1, 0, 0);
    run(2'd1, 1'b0, 0, 0);   // back-to-back from here (R8)
    run(2'd2, 1'b1, 0, 0);
    run(2'd3, 1'b0, 0, 0);
    run(2'd2, 1'b0, 1, 0);   // R9 comparator toggles during evaluation
    run(2'd1, 1'b1, 1, 0);
    run(2'd3, 1'b1, 0, 1);   // R7
    run(2'd0, 1'b0, 0, 1);
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R6 one done per request", q.size(), 0);
    chk(load_o == 1'b1, "R5 load held while idle", load_o, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule